// File: doc/BRIEF.md
# Per-Master Peripheral Security Filter

This block sits on a shared register bus in front of four peripherals: a random number generator, a public-key accelerator, a second cipher engine and the key registers of a first cipher engine. Every request carries a one-bit master identifier that names the issuing core. One core is trusted (the secure core) and the other is not. A four-bit security control register decides, for each peripheral, whether the non-secure core may reach it. Only the secure core may change that register, but either core may read it.

An allowed request is forwarded as a one-cycle strobe to exactly one peripheral. The read data and the error flag come back in that same cycle. A blocked request never reaches the peripheral. A blocked write raises a bus error. A blocked read returns zero and raises no error. A copy of the accelerator's security bit is kept in a retention register that survives a system reset. When a system reset ends and that copy was set, the block sends a single-cycle erase request to the accelerator RAM.

The upper three address bits select a region. Regions 0 to 3 are the peripherals: region 0 is the first cipher engine key, region 1 the second cipher engine, region 2 the accelerator and region 3 the random generator. Region 4 is the control register. Regions 5 to 7 are unmapped. The remaining address bits are passed through as the peripheral offset. Master identifier 1 is the secure core and 0 is the non-secure core.

Top module: `sec_periph_filter`

## Requirements
- R1: After reset the control register reads as zero. No peripheral strobe, no error and no erase request are active while the bus is idle.
- R2: A write by the secure core (`req_mid`=1) to region 4 loads `req_wdata[3:0]` into the control register. The new value governs accesses from the next cycle on, and the write raises no error.
- R3: A write by the non-secure core (`req_mid`=0) to region 4 leaves the control register unchanged and raises `rsp_err` in the same cycle.
- R4: A read of region 4 by either core returns the control register zero-extended to the data width, with no error.
- R5: When a peripheral's security bit is 0, an access by either core to its region raises only that peripheral's bit in `tgt_req`. A read returns that peripheral's `tgt_rdata` slice in the same cycle, and there is no error.
- R6: When a peripheral's security bit is 1, a non-secure write to it produces no strobe and raises `rsp_err` in the same cycle.
- R7: When a peripheral's security bit is 1, a non-secure read of it produces no strobe, returns zero and raises no error.
- R8: A set security bit does not restrict the secure core, which reaches the peripheral as in R5.
- R9: Security bit i guards region i. Bit 3 guards the random generator, bit 2 the accelerator, bit 1 the second cipher engine and bit 0 the first cipher engine key.
- R10: Accesses to regions 5 to 7 produce no strobe, return zero and raise no error.
- R11: If the accelerator bit (bit 2) is set when a system reset begins, `pka_erase` is high for exactly one cycle, starting one cycle after reset is released. If the bit is clear, no pulse appears.
- R12: Asserting `ret_rst` clears the retention copy, so no erase pulse follows that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| ret_rst | input | 1 | Synchronous active-high power-on reset of the retention register |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mid | input | 1 | Master identifier, 1 = secure core |
| req_addr | input | ADDR_W | Address; the top 3 bits select the region |
| req_wdata | input | DATA_W | Write data |
| tgt_req | output | 4 | Per-peripheral request strobe |
| tgt_write | output | 1 | Write flag forwarded to the peripherals |
| tgt_addr | output | ADDR_W-3 | Offset within the peripheral |
| tgt_wdata | output | DATA_W | Write data forwarded to the peripherals |
| tgt_rdata | input | 4*DATA_W | Read data from the peripherals, slice i from peripheral i |
| rsp_rdata | output | DATA_W | Read data returned to the master |
| rsp_err | output | 1 | Bus error response |
| pka_erase | output | 1 | Single-cycle accelerator RAM erase request |

## Verification
Every region is accessed by both cores, with both reads and writes, under control values of zero, 0101 and 1010. Comparing these runs shows that each security bit guards only its own region and that the secure core is never restricted. Under the same lock, blocked writes and blocked reads are told apart by the error and read-data outputs. Non-secure writes to the control register are followed by read-back. This confirms that the register kept its value. Reset is applied three times: with the accelerator bit set, with it clear, and with the retention register cleared. Only the first should produce the erase pulse.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;

    localparam int NUM_TGT = 4;
    localparam int SEL_W   = 3;
    localparam logic SECURE_MID = 1'b1;

    typedef enum logic [SEL_W-1:0] {
        RG_KEY1  = 3'd0,
        RG_CIPH2 = 3'd1,
        RG_PKA   = 3'd2,
        RG_RNG   = 3'd3,
        RG_CTRL  = 3'd4
    } region_e;

    // bit 3 down to bit 0: the order matters, bit i guards region i
    typedef struct packed {
        logic rng;
        logic pka;
        logic ciph2;
        logic key1;
    } sec_ctrl_t;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic             secure;
        logic [SEL_W-1:0] region;
    } req_info_t;

    function automatic logic is_periph(logic [SEL_W-1:0] r);
        return int'(r) < NUM_TGT;
    endfunction

endpackage

// File: rtl/sf_ctrl_reg.sv
module sf_ctrl_reg
    import sfilt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  req_info_t          info,
    input  logic [NUM_TGT-1:0] wbits,
    output sec_ctrl_t          ctrl_q,
    output logic               deny
);

    logic to_ctrl_wr;
    logic load;

    always_comb begin
        to_ctrl_wr = info.valid && info.write && (info.region == RG_CTRL);
        load       = to_ctrl_wr && info.secure;
        deny       = to_ctrl_wr && !info.secure;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (load) begin
            ctrl_q <= sec_ctrl_t'(wbits);
        end
    end

    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        deny |=> $stable(ctrl_q));

    p_ctrl_load_r2: assert property (@(posedge clk) disable iff (rst)
        (info.valid && info.write && info.secure && info.region == RG_CTRL)
        |=> (ctrl_q == sec_ctrl_t'($past(wbits))));

endmodule

// File: rtl/sf_gate.sv
module sf_gate
    import sfilt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  req_info_t          info,
    input  sec_ctrl_t          ctrl,
    output logic [NUM_TGT-1:0] strobe,
    output logic               blk_err
);

    logic [NUM_TGT-1:0] lock_vec;
    logic [NUM_TGT-1:0] hit;
    logic [NUM_TGT-1:0] wr_blocked;

    assign lock_vec = ctrl;

    for (genvar i = 0; i < NUM_TGT; i++) begin : g_tgt
        logic locked;
        always_comb begin
            hit[i]        = info.valid && (int'(info.region) == i);
            locked        = lock_vec[i] && !info.secure;
            strobe[i]     = hit[i] && !locked;
            wr_blocked[i] = hit[i] && locked && info.write;
        end
    end

    assign blk_err = |wr_blocked;

    p_strobe_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));

    p_strobe_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        (strobe != '0) |-> (info.valid && is_periph(info.region)));

endmodule

// File: rtl/sf_erase_retain.sv
module sf_erase_retain (
    input  logic clk,
    input  logic rst,
    input  logic ret_rst,
    input  logic sec_bit,
    output logic erase
);

    logic kept;
    logic was_rst;

    // kept follows the live bit until the first reset edge, then holds
    always_ff @(posedge clk) begin
        if (ret_rst) begin
            kept    <= 1'b0;
            was_rst <= 1'b1;
            erase   <= 1'b0;
        end else begin
            was_rst <= rst;
            erase   <= was_rst && !rst && kept;
            if (!was_rst) begin
                kept <= sec_bit;
            end
        end
    end

    p_erase_single_r11: assert property (@(posedge clk) disable iff (ret_rst)
        erase |=> !erase);

    p_erase_after_reset_r11: assert property (@(posedge clk) disable iff (ret_rst)
        erase |-> $past(rst, 2));

endmodule

// File: rtl/sec_periph_filter.sv
module sec_periph_filter
    import sfilt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ret_rst,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_mid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [DATA_W-1:0]         req_wdata,
    output logic [NUM_TGT-1:0]        tgt_req,
    output logic                      tgt_write,
    output logic [ADDR_W-SEL_W-1:0]   tgt_addr,
    output logic [DATA_W-1:0]         tgt_wdata,
    input  logic [NUM_TGT*DATA_W-1:0] tgt_rdata,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic                      rsp_err,
    output logic                      pka_erase
);

    localparam int OFS_W = ADDR_W - SEL_W;

    req_info_t info;
    sec_ctrl_t ctrl;
    logic      ctrl_deny;
    logic      gate_err;
    logic      rst_any;

    assign rst_any     = rst || ret_rst;
    assign info.valid  = req_valid;
    assign info.write  = req_write;
    assign info.secure = (req_mid == SECURE_MID);
    assign info.region = req_addr[ADDR_W-1 -: SEL_W];

    sf_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst_any),
        .info   (info),
        .wbits  (req_wdata[NUM_TGT-1:0]),
        .ctrl_q (ctrl),
        .deny   (ctrl_deny)
    );

    sf_gate u_gate (
        .clk     (clk),
        .rst     (rst_any),
        .info    (info),
        .ctrl    (ctrl),
        .strobe  (tgt_req),
        .blk_err (gate_err)
    );

    sf_erase_retain u_erase (
        .clk     (clk),
        .rst     (rst),
        .ret_rst (ret_rst),
        .sec_bit (ctrl.pka),
        .erase   (pka_erase)
    );

    assign tgt_write = req_write;
    assign tgt_addr  = req_addr[OFS_W-1:0];
    assign tgt_wdata = req_wdata;
    assign rsp_err   = ctrl_deny || gate_err;

    always_comb begin
        rsp_rdata = '0;
        if (req_valid && !req_write) begin
            if (info.region == RG_CTRL) begin
                rsp_rdata = DATA_W'(ctrl);
            end
            for (int i = 0; i < NUM_TGT; i++) begin
                if (tgt_req[i]) begin
                    rsp_rdata = tgt_rdata[i*DATA_W +: DATA_W];
                end
            end
        end
    end

    p_err_no_strobe_r6: assert property (@(posedge clk) disable iff (rst_any)
        rsp_err |-> (tgt_req == '0));

    p_read_no_err_r7: assert property (@(posedge clk) disable iff (rst_any)
        (req_valid && !req_write) |-> !rsp_err);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst_any)
        !req_valid |-> (tgt_req == '0 && !rsp_err && rsp_rdata == '0));

endmodule

// File: tb/sim_sec_periph_filter.sv
module sim_sec_periph_filter;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;
    localparam int NT     = 4;
    localparam int OFS_W  = ADDR_W - 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ret_rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_mid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [NT-1:0]     tgt_req;
    logic              tgt_write;
    logic [OFS_W-1:0]  tgt_addr;
    logic [DATA_W-1:0] tgt_wdata;
    logic [NT*DATA_W-1:0] tgt_rdata;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_err;
    logic              pka_erase;

    int checks = 0;
    int errors = 0;
    int model_ctrl = 0;
    bit done = 0;

    always #5 clk = ~clk;

    function automatic logic [DATA_W-1:0] tdata(int i);
        return 32'h5A00_0000 + DATA_W'(i) * 32'h0000_0101;
    endfunction

    for (genvar g = 0; g < NT; g++) begin : g_rd
        assign tgt_rdata[g*DATA_W +: DATA_W] = tdata(g);
    end

    sec_periph_filter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .ret_rst(ret_rst),
        .req_valid(req_valid), .req_write(req_write), .req_mid(req_mid),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .tgt_req(tgt_req), .tgt_write(tgt_write), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pka_erase(pka_erase)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(string req, bit v, bit wr, bit mid, int region, int wdata);
        logic [NT-1:0]     e_req = '0;
        bit                e_err = 0;
        logic [DATA_W-1:0] e_rd  = '0;
        bit                locked;
        @(negedge clk);
        req_valid = v;
        req_write = wr;
        req_mid   = mid;
        req_addr  = {3'(region), 9'h03C};
        req_wdata = wdata;
        if (region < NT) begin
            locked = model_ctrl[region] && !mid;
            if (v && !locked) e_req = NT'(1 << region);
            if (v && locked && wr) e_err = 1;
            if (v && !wr && !locked) e_rd = tdata(region);
        end else if (region == 4) begin
            if (v && wr && !mid) e_err = 1;
            if (v && !wr) e_rd = DATA_W'(model_ctrl);
        end
        #4;
        check({req, " strobe"}, 64'(tgt_req), 64'(e_req));
        check({req, " err"}, 64'(rsp_err), 64'(e_err));
        check({req, " rdata"}, 64'(rsp_rdata), 64'(e_rd));
        check({req, " no erase"}, 64'(pka_erase), 64'd0);
        @(posedge clk);
        if (v && wr && region == 4 && mid) model_ctrl = wdata & 4'hF;
    endtask

    task automatic do_reset(string req, bit with_ret);
        int exp_e;
        @(negedge clk);
        req_valid = 0;
        exp_e = with_ret ? 0 : model_ctrl[2];
        rst = 1;
        ret_rst = with_ret;
        repeat (3) @(negedge clk);
        check({req, " erase low in reset"}, 64'(pka_erase), 64'd0);
        rst = 0;
        ret_rst = 0;
        model_ctrl = 0;
        @(negedge clk);
        check({req, " erase pulse"}, 64'(pka_erase), 64'(exp_e));
        @(negedge clk);
        check({req, " erase single cycle"}, 64'(pka_erase), 64'd0);
    endtask

    task automatic sweep(string req);
        for (int r = 0; r < NT; r++) begin
            for (int m = 0; m < 2; m++) begin
                access(req, 1, 0, m[0], r, 0);
                access(req, 1, 1, m[0], r, 32'h1234);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        ret_rst = 0;
        @(negedge clk);
        check("R11 no erase after power-on", 64'(pka_erase), 64'd0);
        // R1 reset state
        access("R1 idle", 0, 0, 0, 0, 0);
        access("R1 ctrl reads zero", 1, 0, 0, 4, 0);
        // R5 all open
        sweep("R5 open");
        // R2 load, R4 read back by both
        access("R2 secure write ctrl", 1, 1, 1, 4, 32'hFFFF_FFF5);
        access("R4 read ctrl nonsec", 1, 0, 0, 4, 0);
        access("R4 read ctrl sec", 1, 0, 1, 4, 0);
        // R3 non-secure write ignored
        access("R3 nonsec write ctrl", 1, 1, 0, 4, 32'hF);
        access("R3 ctrl unchanged", 1, 0, 1, 4, 0);
        // R6 R7 R8 R9 with 0101 then 1010
        sweep("R9 ctrl 0101 R6 R7 R8");
        access("R2 secure write ctrl", 1, 1, 1, 4, 32'hA);
        sweep("R9 ctrl 1010 R6 R7 R8");
        // R10 unmapped regions
        for (int r = 5; r < 8; r++) begin
            access("R10 unmapped read", 1, 0, 0, r, 0);
            access("R10 unmapped write", 1, 1, 1, r, 32'h7);
        end
        // R11 erase when accelerator bit set
        access("R11 set accel bit", 1, 1, 1, 4, 32'h4);
        access("R11 idle", 0, 0, 0, 0, 0);
        do_reset("R11 bit set", 0);
        access("R1 ctrl zero after reset", 1, 0, 0, 4, 0);
        do_reset("R11 bit clear", 0);
        // R12 retention clear
        access("R12 set accel bit", 1, 1, 1, 4, 32'h4);
        access("R12 locked accel", 1, 0, 0, 2, 0);
        do_reset("R12 retention cleared", 1);
        access("R1 open after reset", 1, 0, 0, 2, 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule